// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block sits between a synchronous requester and a bank of four byte-wide asynchronous static RAMs that share one 19-bit address bus and one active-low output-enable line. It accepts a one-cycle read or write request with a 4-bit byte mask, and then plays out a pin sequence timed in whole clocks. The sequence meets the memories' access, pulse-width, setup and hold minimums. When the access is complete, the block raises a one-cycle completion pulse.

Each byte lane has its own active-low chip select and write strobe. A request can therefore touch any combination of lanes, giving 8-, 16-, 24- or 32-bit accesses. Lanes that are not selected stay in standby. All nanosecond minimums and the clock period are parameters, and each is rounded up to whole clocks at elaboration. With the default 10 ns clock, a read takes 5 clocks and a write takes 4 clocks from acceptance to completion. The data bus is modelled as separate out, in and drive-enable vectors. Pad tristate logic and the memory arrays belong to the surrounding design.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever idle, all lane selects and write strobes are high, the shared output enable is high, the data-bus drive enable is low and the completion pulse is low.
- R2: During a read, the selected lanes have their select low, the shared output enable is low, every write strobe is high and the data bus is not driven.
- R3: During a write, the shared output enable stays high for the whole access. The data-bus drive enable is high from the clock before the strobe falls until the clock after it rises.
- R4: A lane whose mask bit is 0 keeps its select and write strobe high for the whole access. Mask bit n controls data bits 8n+7..8n.
- R5: A write strobe stays low for exactly 2 clocks at the default timing (at least 20 ns). Write data is driven for at least 3 clocks before the strobe rises (at least 15 ns of setup).
- R6: Address and write data do not change while any lane is selected. They are still held, with the lane still selected, for one clock after the strobe rises.
- R7: A read returns, with the completion pulse, the addressed bytes of the selected lanes. Bytes of unselected lanes return as zero. The data is sampled on the last clock of the access window.
- R8: The completion pulse lasts one clock. It comes 5 clocks after the accepting edge for a read and 4 clocks after for a write, at the default timing.
- R9: A request raised while an access is in progress is ignored. It starts no second access and changes no memory.
- R10: A write strobe is never low on a lane whose select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data, byte n on bits 8n+7..8n |
| req_mask | input | 4 | Byte-lane select mask |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| rsp_done | output | 1 | One-clock completion pulse |
| mem_addr | output | 19 | Shared memory address |
| mem_ce_n | output | 4 | Per-lane active-low select |
| mem_we_n | output | 4 | Per-lane active-low write strobe |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq_out | output | 32 | Data driven toward the memories |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 32 | Data returned by the memories |

## Verification
The embedded properties check, on every clock, the rules that hold at the pins:
- the output enable stays high under a write strobe, and the data bus is never driven while it is low;
- no strobe falls outside its lane's select;
- the address and data stay stable while a lane is selected;
- every strobe lasts at least its minimum and is followed by a held clock;
- the completion pulse lasts one clock.

Only the bench scenarios can show that the right bytes reach and return from the right lanes, including zero fill for masked lanes. They also show the exact completion latency for each access type and that a request raised mid-access leaves the memory contents unchanged.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } sramc_state_e;

    // Round a nanosecond minimum up to whole clocks.
    function automatic int ns_to_clk(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_lane_decode.sv
// Per-lane select and write strobe from the shared phase flags and the mask.
module sramc_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             sel_act,
    input  logic             wr_act,
    input  logic [LANES-1:0] lane_mask,
    output logic [LANES-1:0] ce_n,
    output logic [LANES-1:0] we_n
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign ce_n[l] = ~(sel_act & lane_mask[l]);
        assign we_n[l] = ~(wr_act & lane_mask[l]);
    end
endmodule

// File: rtl/sramc_byte_gate.sv
// Zeroes the bytes of lanes that are not part of the access.
module sramc_byte_gate #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [LANES-1:0]        lane_mask,
    output logic [LANES*LANE_W-1:0] dout
);
    for (genvar l = 0; l < LANES; l++) begin : g_byte
        assign dout[l*LANE_W +: LANE_W] = lane_mask[l] ? din[l*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int LANES    = 4,
    parameter int LANE_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int T_ACC_NS = 25,
    parameter int T_CYC_NS = 25,
    parameter int T_WP_NS  = 20,
    parameter int T_DS_NS  = 15,
    parameter int T_AH_NS  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [LANES*LANE_W-1:0]  req_wdata,
    input  logic [LANES-1:0]         req_mask,
    output logic [LANES*LANE_W-1:0]  rsp_rdata,
    output logic                     rsp_done,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [LANES-1:0]         mem_ce_n,
    output logic [LANES-1:0]         mem_we_n,
    output logic                     mem_oe_n,
    output logic [LANES*LANE_W-1:0]  mem_dq_out,
    output logic                     mem_dq_oe,
    input  logic [LANES*LANE_W-1:0]  mem_dq_in
);
    localparam int DATA_W  = LANES * LANE_W;
    localparam int ACC_CLK = imax(1, ns_to_clk(T_ACC_NS, CLK_NS));
    localparam int CYC_CLK = imax(1, ns_to_clk(T_CYC_NS, CLK_NS));
    localparam int WP_CLK  = imax(1, ns_to_clk(T_WP_NS, CLK_NS));
    localparam int DS_CLK  = ns_to_clk(T_DS_NS, CLK_NS);
    localparam int AH_CLK  = imax(1, ns_to_clk(T_AH_NS, CLK_NS));
    // Data is already driven in SETUP, so the strobe needs DS_CLK-1 more.
    localparam int WR_STB  = imax(WP_CLK, DS_CLK - 1);
    localparam int RD_HOLD = imax(1, CYC_CLK - 1 - ACC_CLK);
    localparam int WR_HOLD = imax(AH_CLK, CYC_CLK - 1 - WR_STB);
    localparam int CNT_MAX = imax(imax(ACC_CLK, WR_STB), imax(RD_HOLD, WR_HOLD));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        sramc_state_e        st;
        logic [CNT_W-1:0]    cnt;
        logic                wr;
        logic [LANES-1:0]    mask;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                done;
        logic                sel_act;
        logic                wr_act;
        logic                rd_act;
        logic                dq_oe;
    } ctrl_t;

    ctrl_t               ctl_d, ctl_q;
    logic [DATA_W-1:0]   rd_gated;

    sramc_byte_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_gate (
        .din       (mem_dq_in),
        .lane_mask (ctl_q.mask),
        .dout      (rd_gated)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req) begin
                    ctl_d.st    = ST_SETUP;
                    ctl_d.wr    = req_write;
                    ctl_d.mask  = req_mask;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.cnt   = '0;
                end
            end
            ST_SETUP: begin
                ctl_d.st  = ST_STROBE;
                ctl_d.cnt = ctl_q.wr ? CNT_W'(WR_STB - 1) : CNT_W'(ACC_CLK - 1);
            end
            ST_STROBE: begin
                if (ctl_q.cnt == '0) begin
                    if (!ctl_q.wr) begin
                        ctl_d.rdata = rd_gated;
                    end
                    ctl_d.st  = ST_HOLD;
                    ctl_d.cnt = ctl_q.wr ? CNT_W'(WR_HOLD - 1) : CNT_W'(RD_HOLD - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st   = ST_DONE;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase

        // Pin phase flags follow the next state, so they switch with it.
        ctl_d.sel_act = (ctl_d.st == ST_SETUP) || (ctl_d.st == ST_STROBE) ||
                        ((ctl_d.st == ST_HOLD) && ctl_d.wr);
        ctl_d.wr_act  = ctl_d.wr && (ctl_d.st == ST_STROBE);
        ctl_d.rd_act  = !ctl_d.wr && ((ctl_d.st == ST_SETUP) || (ctl_d.st == ST_STROBE));
        ctl_d.dq_oe   = ctl_d.wr && ((ctl_d.st == ST_SETUP) || (ctl_d.st == ST_STROBE) ||
                                     (ctl_d.st == ST_HOLD));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sramc_lane_decode #(.LANES(LANES)) u_dec (
        .sel_act   (ctl_q.sel_act),
        .wr_act    (ctl_q.wr_act),
        .lane_mask (ctl_q.mask),
        .ce_n      (mem_ce_n),
        .we_n      (mem_we_n)
    );

    assign mem_addr   = ctl_q.addr;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.dq_oe;
    assign mem_oe_n   = ~ctl_q.rd_act;
    assign rsp_rdata  = ctl_q.rdata;
    assign rsp_done   = ctl_q.done;

    // Length of the current run of write-strobe clocks, for the pulse check.
    logic [CNT_W:0] wlow_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wlow_q <= '0;
        end else if (~&mem_we_n) begin
            wlow_q <= wlow_q + 1'b1;
        end else begin
            wlow_q <= '0;
        end
    end

    a_r3_g_high_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (~&mem_we_n) |-> mem_oe_n);

    a_r2_no_drive_while_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    a_r10_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mem_we_n) & mem_ce_n) == '0);

    a_r6_addr_stable_selected: assert property (@(posedge clk) disable iff (!rst_n)
        ((~&mem_ce_n) && $past(~&mem_ce_n)) |-> $stable(mem_addr));

    a_r6_data_stable_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    a_r6_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(~&mem_we_n) && (&mem_we_n)) |-> (mem_dq_oe && (~&mem_ce_n)));

    a_r5_strobe_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        ((wlow_q != '0) && (&mem_we_n)) |-> (wlow_q >= (CNT_W+1)'(WP_CLK)));

    a_r8_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT_RD = 5;
    localparam int LAT_WR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_done;
    logic [18:0] mem_addr;
    logic [3:0]  mem_ce_n;
    logic [3:0]  mem_we_n;
    logic        mem_oe_n;
    logic [31:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_in = '0;

    int n_checks = 0;
    int n_fails  = 0;

    sram_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
        end
    endtask

    // Memory model contents and the bench's own expected contents.
    logic [7:0] sram [int];
    logic [7:0] refm [int];

    function automatic int key(input int lane, input logic [18:0] a);
        return lane * 524288 + int'(a);
    endfunction

    function automatic logic [7:0] sram_rd(input int k);
        return sram.exists(k) ? sram[k] : 8'h00;
    endfunction

    function automatic logic [31:0] exp_read(input logic [18:0] a, input logic [3:0] m);
        logic [31:0] v = '0;
        for (int l = 0; l < 4; l++) begin
            if (m[l]) v[l*8 +: 8] = refm.exists(key(l, a)) ? refm[key(l, a)] : 8'h00;
        end
        return v;
    endfunction

    // Pin monitor and memory model, evaluated away from the active edge.
    bit          busy = 1'b0;
    bit          cur_wr = 1'b0;
    logic [3:0]  cur_mask = '0;
    logic [3:0]  prev_we = 4'hF;
    logic [3:0]  prev_ce = 4'hF;
    logic [18:0] prev_addr = '0;
    int          wl_run = 0;
    int          oe_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // strobe edge: commit data into the model
            for (int l = 0; l < 4; l++) begin
                if (!prev_we[l] && mem_we_n[l] && !mem_ce_n[l])
                    sram[key(l, mem_addr)] = mem_dq_out[l*8 +: 8];
            end
            if ((~&prev_we) && (&mem_we_n)) begin
                chk(wl_run == 2, "R5 strobe width", wl_run, 2);
                chk(oe_run >= 3, "R5 data setup", oe_run, 3);
                chk(mem_dq_oe && (mem_ce_n == prev_ce) && (mem_addr == prev_addr),
                    "R6 hold after strobe", {mem_dq_oe, mem_ce_n, mem_addr[18:0]},
                    {1'b1, prev_ce, prev_addr});
            end
            if ((~&mem_ce_n) && (~&prev_ce))
                chk(mem_addr == prev_addr, "R6 address stable", mem_addr, prev_addr);
            if (~&mem_we_n) begin
                chk(mem_oe_n == 1'b1, "R3 output enable high in write", mem_oe_n, 1);
                chk(((~mem_we_n) & mem_ce_n) == 4'h0, "R10 strobe inside select", mem_we_n, mem_ce_n);
            end
            if (busy) begin
                chk(((~mem_ce_n) & (~cur_mask)) == 4'h0 && ((~mem_we_n) & (~cur_mask)) == 4'h0,
                    "R4 unselected lanes idle", {mem_ce_n, mem_we_n}, {4'hF, 4'hF});
                if (!cur_wr && (~&mem_ce_n))
                    chk(!mem_oe_n && (&mem_we_n) && !mem_dq_oe && (mem_ce_n == ~cur_mask),
                        "R2 read pin pattern", {mem_oe_n, mem_we_n, mem_dq_oe, mem_ce_n},
                        {1'b0, 4'hF, 1'b0, ~cur_mask});
                if (cur_wr && (~&mem_we_n))
                    chk(mem_we_n == ~cur_mask, "R3 write strobes", mem_we_n, ~cur_mask);
            end
            wl_run = (~&mem_we_n) ? wl_run + 1 : 0;
            oe_run = mem_dq_oe ? oe_run + 1 : 0;
        end
        for (int l = 0; l < 4; l++) begin
            mem_dq_in[l*8 +: 8] = (!mem_ce_n[l] && !mem_oe_n && mem_we_n[l]) ?
                                  sram_rd(key(l, mem_addr)) : 8'hA5;
        end
        prev_we   = mem_we_n;
        prev_ce   = mem_ce_n;
        prev_addr = mem_addr;
    end

    task automatic access(input bit wr, input logic [18:0] a, input logic [31:0] d,
                          input logic [3:0] m);
        int lat = 0;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        cur_mask = m; cur_wr = wr; busy = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(rsp_done == 1'b0, "R8 no early done", rsp_done, 0);
        if (wr) chk(mem_dq_oe == 1'b1 && (&mem_we_n), "R3 drive before strobe",
                    {mem_dq_oe, mem_we_n}, {1'b1, 4'hF});
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (rsp_done) begin
                lat = k;
                break;
            end
        end
        chk(lat == (wr ? LAT_WR : LAT_RD), "R8 latency", lat, wr ? LAT_WR : LAT_RD);
        if (!wr) chk(rsp_rdata == exp_read(a, m), "R7 read data", rsp_rdata, exp_read(a, m));
        if (wr) begin
            for (int l = 0; l < 4; l++) if (m[l]) refm[key(l, a)] = d[l*8 +: 8];
        end
        @(negedge clk);
        chk(rsp_done == 1'b0, "R8 done one clock", rsp_done, 0);
        chk((&mem_ce_n) && (&mem_we_n) && mem_oe_n && !mem_dq_oe, "R1 idle pins",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, {4'hF, 4'hF, 1'b1, 1'b0});
        busy = 1'b0;
    endtask

    initial begin
        int dones;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk((&mem_ce_n) && (&mem_we_n) && mem_oe_n && !mem_dq_oe && !rsp_done,
            "R1 reset state", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done},
            {4'hF, 4'hF, 1'b1, 1'b0, 1'b0});
        rst_n = 1'b1;

        // R9: a request raised mid-access must be dropped
        @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = 19'd3; req_wdata = 32'h11223344; req_mask = 4'hF;
        cur_mask = 4'hF; cur_wr = 1'b1; busy = 1'b1;
        @(negedge clk);
        req_addr = 19'd5; req_wdata = 32'hDEADBEEF;
        @(negedge clk);
        req = 1'b0;
        dones = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (rsp_done) dones++;
        end
        busy = 1'b0;
        chk(dones == 1, "R9 single completion", dones, 1);
        for (int l = 0; l < 4; l++) refm[key(l, 19'd3)] = 8'(32'h11223344 >> (8 * l));
        access(1'b0, 19'd5, '0, 4'hF);
        access(1'b0, 19'd3, '0, 4'hF);

        // Directed lane combinations and the top address
        access(1'b1, 19'h7FFFF, 32'hCAFEF00D, 4'hF);
        access(1'b1, 19'h7FFFF, 32'h00990000, 4'b0100);
        access(1'b0, 19'h7FFFF, '0, 4'hF);
        access(1'b0, 19'h7FFFF, '0, 4'b0101);
        access(1'b1, 19'd0, 32'hA1B2C3D4, 4'b0011);
        access(1'b0, 19'd0, '0, 4'b1100);
        access(1'b0, 19'd0, '0, 4'b0000);

        // Random mix
        for (int i = 0; i < 80; i++) begin
            bit          w = 1'($urandom % 2);
            logic [18:0] a = ($urandom % 4 == 0) ? 19'h7FFFF : 19'($urandom % 16);
            access(w, a, $urandom, 4'($urandom % 16));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule